// File: doc/BRIEF.md
# Indirect 64-bit Register Window

This block sits on a 32-bit host bus and gives it access to a 64-bit register space that the host cannot address directly. The host sees a handful of 32-bit words: an upper data half, a lower data half, a command word, a reset word and a status word. To write an inner register, the host fills both data halves and then writes the command word with its top bit set and the inner address in its low bits. To read one, the host writes the command word with the top bit clear, waits until the busy flag drops, and then reads the two halves.

On the inner side the block holds one request (write enable or read enable, with address and write data) until the inner register file returns a one-cycle acknowledge. A failed action sets a sticky error bit. Three actions fail: a command that arrives while an access is still outstanding, which is dropped, and a read or a write to an address beyond the populated range, which is never issued. Any write to the reset word clears the error and abandons an outstanding access.

Top module: `reg64_window_bridge`

## Requirements
- R1: After reset, every host-readable word reads 0 and neither inner write enable nor inner read enable is asserted.
- R2: The word at byte offset 0x00 holds bits 63:32 and the word at 0x04 holds bits 31:0 of the 64-bit value. Each reads back what was last written to it and together they drive the inner write data.
- R3: A command word (offset 0x08) with bit 31 set and a populated address raises the inner write enable in the cycle after the command. The address is command bits IAW-1:0. Enable, address and data stay unchanged until the cycle in which the acknowledge is seen, and only one inner write results.
- R4: A command word with bit 31 clear and a populated address raises the inner read enable in the same way. The acknowledged read data is loaded into the halves: bits 63:32 to offset 0x00 and bits 31:0 to offset 0x04.
- R5: Status (offset 0x1C) bit 0 is the busy flag. It reads 1 from the cycle after an accepted command until the cycle after the acknowledge.
- R6: A command word written while busy sets status bit 31 and is dropped. The outstanding access continues unchanged and no further inner access follows.
- R7: A command whose address field (bits 30:0) is N_REGS or more sets status bit 31 and issues no inner access. If it is a read, both halves become 0.
- R8: Writes to the data halves while busy are ignored.
- R9: A write of any value to the reset word (offset 0x18) clears status bit 31 and the busy flag and withdraws an outstanding inner request in the next cycle.
- R10: Status bit 31 stays set through later successful commands until the reset word is written.
- R11: The command word reads back the last command written while not busy. Offsets 0x0C, 0x10 and 0x14 read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| h_wr | input | 1 | Host write strobe, one cycle per word |
| h_rd | input | 1 | Host read strobe |
| h_addr | input | 5 | Host byte offset within the window |
| h_wdata | input | 32 | Host write data |
| h_rdata | output | 32 | Host read data, valid with h_rvalid |
| h_rvalid | output | 1 | Read data valid, one cycle after h_rd |
| in_addr | output | IAW | Inner register address |
| in_wdata | output | 64 | Inner write data |
| in_we | output | 1 | Inner write request, held until acknowledge |
| in_re | output | 1 | Inner read request, held until acknowledge |
| in_rdata | input | 64 | Inner read data, sampled with in_ack |
| in_ack | input | 1 | Inner access complete, one cycle |

## Verification
A host write takes effect at the clock edge that samples it, so an inner request is checked in the low phase right after the command's edge. Read data arrives one edge after the read strobe, and the scoreboard pops it only when h_rvalid is high. The inner model acknowledges four edges after a request rises and the block clears busy one edge later. The bench therefore reads status one idle cycle after a command, which is inside the busy window, and it issues follow-on commands and data writes at that point. It checks inner memory and completion counts only after a twelve-cycle settle. Reset-word aborts are issued two edges into a request, before the acknowledge.

// File: rtl/reg64_window_bridge.sv
module reg64_window_bridge #(
  parameter int IAW    = 6,
  parameter int N_REGS = 40
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           h_wr,
  input  logic           h_rd,
  input  logic [4:0]     h_addr,
  input  logic [31:0]    h_wdata,
  output logic [31:0]    h_rdata,
  output logic           h_rvalid,
  output logic [IAW-1:0] in_addr,
  output logic [63:0]    in_wdata,
  output logic           in_we,
  output logic           in_re,
  input  logic [63:0]    in_rdata,
  input  logic           in_ack
);
  localparam logic [2:0] W_HI = 3'd0, W_LO = 3'd1, W_CMD = 3'd2, W_RST = 3'd6, W_STS = 3'd7;

  logic [31:0] hi_q, lo_q, cmd_q;
  logic        busy_q, err_q, op_wr_q;

  wire [2:0] word    = h_addr[4:2];
  wire       wr_hi   = h_wr && word == W_HI;
  wire       wr_lo   = h_wr && word == W_LO;
  wire       wr_cmd  = h_wr && word == W_CMD;
  wire       wr_rst  = h_wr && word == W_RST;
  wire       far     = h_wdata[30:0] >= 31'(N_REGS);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hi_q    <= '0;
      lo_q    <= '0;
      cmd_q   <= '0;
      busy_q  <= 1'b0;
      err_q   <= 1'b0;
      op_wr_q <= 1'b0;
    end else if (wr_rst) begin
      busy_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      if (wr_cmd) begin
        if (busy_q || far) err_q <= 1'b1;
        if (!busy_q) begin
          cmd_q <= h_wdata;
          if (!far) begin
            busy_q  <= 1'b1;
            op_wr_q <= h_wdata[31];
          end else if (!h_wdata[31]) begin
            hi_q <= '0;
            lo_q <= '0;
          end
        end
      end
      if (busy_q && in_ack) begin
        busy_q <= 1'b0;
        if (!op_wr_q) {hi_q, lo_q} <= in_rdata;
      end
      if (!busy_q && wr_hi) hi_q <= h_wdata;
      if (!busy_q && wr_lo) lo_q <= h_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      h_rvalid <= 1'b0;
      h_rdata  <= '0;
    end else begin
      h_rvalid <= h_rd;
      if (h_rd) begin
        case (word)
          W_HI:    h_rdata <= hi_q;
          W_LO:    h_rdata <= lo_q;
          W_CMD:   h_rdata <= cmd_q;
          W_STS:   h_rdata <= {err_q, 30'd0, busy_q};
          default: h_rdata <= '0;
        endcase
      end
    end
  end

  assign in_addr  = cmd_q[IAW-1:0];
  assign in_wdata = {hi_q, lo_q};
  assign in_we    = busy_q && op_wr_q;
  assign in_re    = busy_q && !op_wr_q;
endmodule

// File: rtl/reg64_window_bridge_chk.sv
module reg64_window_bridge_chk #(
  parameter int IAW = 6
) (
  input logic           clk,
  input logic           rst_n,
  input logic           h_wr,
  input logic [4:0]     h_addr,
  input logic [IAW-1:0] in_addr,
  input logic [63:0]    in_wdata,
  input logic           in_we,
  input logic           in_re,
  input logic           in_ack,
  input logic           busy_q,
  input logic           err_q
);
  wire rst_wr = h_wr && h_addr[4:2] == 3'd6;
  wire cmd_wr = h_wr && h_addr[4:2] == 3'd2;
  wire req    = in_we || in_re;

  a_r3_req_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_we && in_re));

  a_r3_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !in_ack && !rst_wr) |=> (req && $stable(in_addr) && $stable(in_wdata)));

  a_r5_busy_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && in_ack) |=> !busy_q);

  a_r6_busy_cmd_err: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && cmd_wr) |=> err_q);

  a_r9_reset_clears: assert property (@(posedge clk) disable iff (!rst_n)
    rst_wr |=> (!busy_q && !err_q && !req));

  a_r10_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (err_q && !rst_wr) |=> err_q);
endmodule

bind reg64_window_bridge reg64_window_bridge_chk #(.IAW(IAW)) u_chk (
  .clk(clk), .rst_n(rst_n), .h_wr(h_wr), .h_addr(h_addr),
  .in_addr(in_addr), .in_wdata(in_wdata), .in_we(in_we), .in_re(in_re),
  .in_ack(in_ack), .busy_q(busy_q), .err_q(err_q)
);

// File: tb/reg64_window_bridge_tb.sv
module reg64_window_bridge_tb;
  localparam int CLK_P  = 10;
  localparam int IAW    = 6;
  localparam int N_REGS = 40;
  localparam int DLY    = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic h_wr = 1'b0, h_rd = 1'b0;
  logic [4:0] h_addr = '0;
  logic [31:0] h_wdata = '0, h_rdata;
  logic h_rvalid;
  logic [IAW-1:0] in_addr;
  logic [63:0] in_wdata, in_rdata;
  logic in_we, in_re, in_ack = 1'b0;

  logic [63:0] mem [N_REGS];
  int cnt = 0, acks = 0, n_chk = 0, n_fail = 0;
  logic [31:0] exp_q[$];
  string tag_q[$];
  bit done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  reg64_window_bridge #(.IAW(IAW), .N_REGS(N_REGS)) u_dut (
    .clk(clk), .rst_n(rst_n), .h_wr(h_wr), .h_rd(h_rd), .h_addr(h_addr),
    .h_wdata(h_wdata), .h_rdata(h_rdata), .h_rvalid(h_rvalid),
    .in_addr(in_addr), .in_wdata(in_wdata), .in_we(in_we), .in_re(in_re),
    .in_rdata(in_rdata), .in_ack(in_ack));

  assign in_rdata = (int'(in_addr) < N_REGS) ? mem[in_addr] : 64'd0;

  always @(posedge clk) begin
    in_ack <= 1'b0;
    if ((in_we || in_re) && !in_ack) begin
      if (cnt == DLY) begin
        in_ack <= 1'b1;
        cnt    <= 0;
        acks   <= acks + 1;
        if (in_we && int'(in_addr) < N_REGS) mem[in_addr] <= in_wdata;
      end else cnt <= cnt + 1;
    end else if (!(in_we || in_re)) cnt <= 0;
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, expv);
    end
  endtask

  always @(negedge clk) begin
    if (h_rvalid) begin
      if (exp_q.size() == 0) chk(1'b0, "scoreboard empty", 64'(h_rdata), 64'd0);
      else begin
        automatic logic [31:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        chk(h_rdata == e, t, 64'(h_rdata), 64'(e));
      end
    end
  end

  task automatic hw(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    h_wr = 1'b1; h_addr = a; h_wdata = d;
    @(negedge clk);
    h_wr = 1'b0;
  endtask

  task automatic hr(input logic [4:0] a, input logic [31:0] e, input string t);
    @(negedge clk);
    h_rd = 1'b1; h_addr = a;
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk);
    h_rd = 1'b0;
  endtask

  task automatic settle();
    repeat (12) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    automatic int a0;
    for (int i = 0; i < N_REGS; i++) mem[i] = {32'hC0DE0000 | 32'(i), 32'h5A5A0000 + 32'(i)};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    chk(!in_we && !in_re, "R1 no request", {62'd0, in_we, in_re}, 64'd0);
    hr(5'h00, 32'h0, "R1 hi zero");
    hr(5'h04, 32'h0, "R1 lo zero");
    hr(5'h08, 32'h0, "R1 cmd zero");
    hr(5'h1C, 32'h0, "R1 status zero");

    hw(5'h00, 32'h1234_5678);
    hw(5'h04, 32'h9ABC_DEF0);
    hr(5'h00, 32'h1234_5678, "R2 hi readback");
    hr(5'h04, 32'h9ABC_DEF0, "R2 lo readback");

    hw(5'h08, 32'h8000_0005);
    chk(in_we && !in_re && in_addr == 6'd5, "R3 write request", {56'd0, in_we, in_re, in_addr}, {56'd0, 2'b10, 6'd5});
    chk(in_wdata == 64'h1234_5678_9ABC_DEF0, "R2 R3 write data order", in_wdata, 64'h1234_5678_9ABC_DEF0);
    hr(5'h1C, 32'h0000_0001, "R5 busy during write");
    settle();
    chk(mem[5] == 64'h1234_5678_9ABC_DEF0, "R3 inner stored", mem[5], 64'h1234_5678_9ABC_DEF0);
    chk(acks == 1, "R3 single access", 64'(acks), 64'd1);
    hr(5'h1C, 32'h0, "R5 idle after write");

    hw(5'h08, 32'h0000_0007);
    chk(in_re && !in_we && in_addr == 6'd7, "R4 read request", {56'd0, in_we, in_re, in_addr}, {56'd0, 2'b01, 6'd7});
    settle();
    hr(5'h00, 32'hC0DE_0007, "R4 upper half");
    hr(5'h04, 32'h5A5A_0007, "R4 lower half");

    hw(5'h00, 32'hAAAA_0001);
    hw(5'h04, 32'hBBBB_0002);
    hw(5'h08, 32'h8000_000A);
    hw(5'h00, 32'hDEAD_BEEF);
    chk(in_wdata == 64'hAAAA_0001_BBBB_0002, "R8 data locked", in_wdata, 64'hAAAA_0001_BBBB_0002);
    settle();
    chk(mem[10] == 64'hAAAA_0001_BBBB_0002, "R8 stored value", mem[10], 64'hAAAA_0001_BBBB_0002);
    hr(5'h00, 32'hAAAA_0001, "R8 hi unchanged");

    a0 = acks;
    hw(5'h08, 32'h0000_0003);
    hw(5'h08, 32'h8000_0004);
    chk(in_re && in_addr == 6'd3, "R6 outstanding kept", {56'd0, in_we, in_re, in_addr}, {56'd0, 2'b01, 6'd3});
    hr(5'h1C, 32'h8000_0001, "R6 error while busy");
    settle();
    chk(acks == a0 + 1, "R6 dropped command", 64'(acks), 64'(a0 + 1));
    chk(mem[4] == {32'hC0DE0004, 32'h5A5A0004}, "R6 target untouched", mem[4], {32'hC0DE0004, 32'h5A5A0004});
    hr(5'h00, 32'hC0DE_0003, "R6 read completed");
    hr(5'h08, 32'h0000_0003, "R11 cmd readback");

    hw(5'h08, 32'h8000_0006);
    settle();
    chk(mem[6] == {32'hC0DE0003, 32'h5A5A0003}, "R10 later command works", mem[6], {32'hC0DE0003, 32'h5A5A0003});
    hr(5'h1C, 32'h8000_0000, "R10 error sticky");

    hw(5'h18, 32'h0);
    hr(5'h1C, 32'h0, "R9 reset clears error");
    a0 = acks;
    hw(5'h08, 32'h0000_0007);
    hw(5'h18, 32'h5555_5555);
    chk(!in_re && !in_we, "R9 request withdrawn", {62'd0, in_we, in_re}, 64'd0);
    hr(5'h1C, 32'h0, "R9 idle after abort");
    settle();
    chk(acks == a0, "R9 no completion", 64'(acks), 64'(a0));

    hw(5'h00, 32'h1111_1111);
    hw(5'h04, 32'h2222_2222);
    hw(5'h08, 32'h0000_0032);
    chk(!in_re && !in_we, "R7 no request", {62'd0, in_we, in_re}, 64'd0);
    hr(5'h1C, 32'h8000_0000, "R7 error flagged");
    hr(5'h00, 32'h0, "R7 hi zeroed");
    hr(5'h04, 32'h0, "R7 lo zeroed");
    hr(5'h08, 32'h0000_0032, "R11 cmd readback far");
    hw(5'h18, 32'h0);
    a0 = acks;
    hw(5'h08, 32'h8000_0033);
    settle();
    chk(acks == a0, "R7 far write not issued", 64'(acks), 64'(a0));
    hr(5'h1C, 32'h8000_0000, "R7 far write error");

    hw(5'h18, 32'h0);
    hw(5'h00, 32'h7777_0000);
    hw(5'h0C, 32'hFFFF_FFFF);
    hw(5'h10, 32'hFFFF_FFFF);
    hw(5'h14, 32'hFFFF_FFFF);
    hr(5'h0C, 32'h0, "R11 hole 0x0C");
    hr(5'h10, 32'h0, "R11 hole 0x10");
    hr(5'h14, 32'h0, "R11 hole 0x14");
    hr(5'h00, 32'h7777_0000, "R11 hi unaffected");
    hr(5'h1C, 32'h0, "R11 status unaffected");

    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0, "scoreboard drained", 64'(exp_q.size()), 64'd0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule